// File: doc/BRIEF.md
# Serial-Output Converter Interface Emulator

This block stands in for the digital side of a successive-approximation converter that is read over a three-wire serial link with a chip-select style convert line. A host controller under test drives the convert line and the serial clock. The block answers the way the converter would: it times a conversion, waits in acquisition, and then shifts a result word out most significant bit first. The data output is split into a data bit and a separate drive enable, so the tri-state pad can sit outside the block. Both host lines are treated as asynchronous. Each passes through a synchronizer of `SYNC_STAGES` flops and then an edge detector clocked by the system clock.

A rising convert line starts a conversion. It lasts `CONV_CYCLES` system clock cycles whatever the convert line does during that time. The result of each conversion is an internal count of conversions, so the host side can check every word it receives. Dropping the convert line before the conversion has finished is a host protocol error and is flagged with a one-cycle pulse.

The controller has four named states:
- `ST_IDLE`: the output is off and no result is pending.
- `ST_CONV`: a conversion is running.
- `ST_READY`: acquisition, with a result waiting to be read.
- `ST_SHIFT`: the output is enabled and bits are being shifted out.

It has these named transitions:
- start: `ST_IDLE`/`ST_READY`/`ST_SHIFT` → `ST_CONV` on a convert rise.
- finish: `ST_CONV` → `ST_READY` when the timer expires.
- select: `ST_READY` → `ST_SHIFT` on a convert fall.
- complete: `ST_SHIFT` → `ST_IDLE` on the last clock fall.

Top module: `sar_serial_emu`

## Requirements
- R1: During and right after reset the drive enable is 0, the error pulse is 0 and the controller is in `ST_IDLE`.
- R2: A convert rise seen in `ST_IDLE`, `ST_READY` or `ST_SHIFT` starts a conversion and leaves the drive enable at 0.
- R3: A conversion lasts exactly `CONV_CYCLES` clock cycles. Convert-line edges during it neither shorten nor restart it.
- R4: When the conversion ends the block enters acquisition (`ST_READY`) with the drive enable still 0.
- R5: A convert fall in `ST_READY` sets the drive enable to 1 and places bit `DATA_W-1` of the result on the data output.
- R6: Each serial clock fall while shifting moves the data output to the next lower bit of the result.
- R7: On the `DATA_W`-th serial clock fall the drive enable returns to 0. Later clock falls leave it at 0.
- R8: A convert rise while shifting turns the drive enable off at once, before all bits are sent, and starts a new conversion.
- R9: A convert fall while a conversion is running gives a single-cycle error pulse, and the output stays off.
- R10: The result of the k-th conversion started after reset (counting from 0) is the value k.
- R11: A convert edge takes effect `SYNC_STAGES+1` clock edges after the cycle in which it is first sampled.
- R12: Serial clock falls outside `ST_SHIFT` have no effect: the drive enable stays 0 and the next read starts from bit `DATA_W-1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| cnv_i | input | 1 | Convert / chip-select line from the host (asynchronous) |
| sck_i | input | 1 | Serial clock from the host (asynchronous) |
| sdo_o | output | 1 | Serial data bit |
| sdo_oe_o | output | 1 | Drive enable for the serial data pad (0 = high impedance) |
| proto_err_o | output | 1 | One-cycle pulse: convert line dropped during a conversion |

## Verification
Every host edge reaches the controller `SYNC_STAGES+1` clock edges after it is sampled. The drive enable, the data bit and the error pulse therefore all change in the cycle the controller acts, with no further output register. The conversion ends `CONV_CYCLES` cycles after the controller enters `ST_CONV`. The reference model in the bench delays the sampled host lines by the same number of edges and steps its own state on every rising clock edge. Outputs are compared with it at every falling edge, so each result is checked in the very cycle it is due. Scenario checks are added on top: the full word read back, an aborted read, an early convert fall, and a latency probe at exactly `SYNC_STAGES` and `SYNC_STAGES+1` edges.

// File: rtl/sse_pkg.sv
package sse_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_READY = 2'd2,
        ST_SHIFT = 2'd3
    } sse_state_e;

endpackage

// File: rtl/sse_edge_sync.sv
// Synchronizer chain plus one history flop for edge detection.
module sse_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic level_o,
    output logic prev_o
);

    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], d_i};
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign prev_o  = chain_q[STAGES];

endmodule

// File: rtl/sse_conv_timer.sv
// Counts the cycles of one conversion.
module sse_conv_timer #(
    parameter int CONV_CYCLES = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic run_i,
    output logic done_o
);

    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= '0;
        end else if (run_i && cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/sse_shifter.sv
// Parallel-load, MSB-first shift register with a bit index.
module sse_shifter #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              shift_i,
    output logic              bit_o,
    output logic              last_o
);

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    logic [DATA_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load_i) begin
            sh_q  <= word_i;
            idx_q <= '0;
        end else if (shift_i) begin
            sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign bit_o  = sh_q[DATA_W-1];
    assign last_o = (idx_q == IDX_LAST);

endmodule

// File: rtl/sar_serial_emu.sv
module sar_serial_emu
    import sse_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int CONV_CYCLES = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnv_i,
    input  logic sck_i,
    output logic sdo_o,
    output logic sdo_oe_o,
    output logic proto_err_o
);

    localparam int N_IN  = 2;
    localparam int IX_CNV = 0;
    localparam int IX_SCK = 1;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] lvl;
    logic [N_IN-1:0] prv;

    assign raw_in[IX_CNV] = cnv_i;
    assign raw_in[IX_SCK] = sck_i;

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        sse_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_i     (raw_in[g]),
            .level_o (lvl[g]),
            .prev_o  (prv[g])
        );
    end

    logic cnv_rise, cnv_fall, sck_fall;
    assign cnv_rise = lvl[IX_CNV] & ~prv[IX_CNV];
    assign cnv_fall = ~lvl[IX_CNV] & prv[IX_CNV];
    assign sck_fall = ~lvl[IX_SCK] & prv[IX_SCK];

    sse_state_e state_q, state_d;
    logic tmr_done, sh_last, sh_bit;
    logic start_conv, load_word, shift_bit;
    logic err_q;
    logic [DATA_W-1:0] conv_cnt_q;
    logic [DATA_W-1:0] sample_q;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cnv_rise) state_d = ST_CONV;
            end
            ST_CONV: begin
                if (tmr_done) state_d = ST_READY;
            end
            ST_READY: begin
                if (cnv_rise)      state_d = ST_CONV;
                else if (cnv_fall) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (cnv_rise)                 state_d = ST_CONV;
                else if (sck_fall && sh_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign start_conv = cnv_rise && (state_q != ST_CONV);
    assign load_word  = (state_q == ST_READY) && !cnv_rise && cnv_fall;
    assign shift_bit  = (state_q == ST_SHIFT) && !cnv_rise && sck_fall && !sh_last;

    // state register and registered side results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            err_q      <= 1'b0;
            conv_cnt_q <= '0;
            sample_q   <= '0;
        end else begin
            state_q <= state_d;
            err_q   <= (state_q == ST_CONV) && cnv_fall;
            if (start_conv) begin
                sample_q   <= conv_cnt_q;
                conv_cnt_q <= conv_cnt_q + 1'b1;
            end
        end
    end

    sse_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_conv),
        .run_i   (state_q == ST_CONV),
        .done_o  (tmr_done)
    );

    sse_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_word),
        .word_i  (sample_q),
        .shift_i (shift_bit),
        .bit_o   (sh_bit),
        .last_o  (sh_last)
    );

    // outputs
    always_comb begin
        sdo_oe_o    = 1'b0;
        sdo_o       = 1'b0;
        proto_err_o = err_q;
        unique case (state_q)
            ST_SHIFT: begin
                sdo_oe_o = 1'b1;
                sdo_o    = sh_bit;
            end
            ST_IDLE, ST_CONV, ST_READY: begin
                sdo_oe_o = 1'b0;
            end
            default: sdo_oe_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sse_checker.sv
module sse_checker
    import sse_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int CONV_CYCLES = 12
) (
    input logic       clk,
    input logic       rst_n,
    input sse_state_e state_q,
    input logic       cnv_rise,
    input logic       cnv_fall,
    input logic       sck_fall,
    input logic       oe,
    input logic       sdo,
    input logic       err
);

    int conv_len;
    int fall_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_len <= 0;
            fall_cnt <= 0;
        end else begin
            conv_len <= (state_q == ST_CONV) ? conv_len + 1 : 0;
            fall_cnt <= !oe ? 0 : (sck_fall ? fall_cnt + 1 : fall_cnt);
        end
    end

    assert_conv_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && conv_len == CONV_CYCLES - 1) |=> (state_q == ST_READY));

    assert_conv_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONV && conv_len < CONV_CYCLES - 1) |=> (state_q == ST_CONV));

    assert_off_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_rise |=> !oe);

    assert_oe_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(cnv_fall));

    assert_bit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && $past(oe) && !$past(sck_fall)) |-> $stable(sdo));

    assert_bit_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (fall_cnt < DATA_W));

    assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!oe && state_q != ST_SHIFT));

endmodule

bind sar_serial_emu sse_checker #(
    .DATA_W      (DATA_W),
    .CONV_CYCLES (CONV_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .cnv_rise (cnv_rise),
    .cnv_fall (cnv_fall),
    .sck_fall (sck_fall),
    .oe       (sdo_oe_o),
    .sdo      (sdo_o),
    .err      (proto_err_o)
);

// File: tb/tb_sar_serial_emu.sv
`timescale 1ns/1ps
module tb_sar_serial_emu;

    localparam int W    = 18;
    localparam int CONV = 12;
    localparam int SYNC = 2;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnv = 1'b0;
    logic sck = 1'b0;
    logic sdo, oe, err;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int err_seen = 0;

    always #2.5 clk = ~clk;

    sar_serial_emu #(.DATA_W(W), .CONV_CYCLES(CONV), .SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .sck_i(sck),
        .sdo_o(sdo), .sdo_oe_o(oe), .proto_err_o(err)
    );

    // reference model: 0 idle, 1 converting, 2 ready, 3 shifting
    bit    cq[$];
    bit    sq[$];
    int    m_st = 0, m_tmr = 0, m_cnt = 0, m_sample = 0, m_word = 0, m_idx = 0;
    bit    m_err = 0;
    string m_tag = "R1";

    task automatic m_start(string tag);
        m_st = 1; m_tmr = 0; m_sample = m_cnt; m_cnt++; m_tag = tag;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            cq = {}; sq = {};
            for (int i = 0; i < SYNC + 2; i++) begin cq.push_back(1'b0); sq.push_back(1'b0); end
            m_st = 0; m_tmr = 0; m_cnt = 0; m_err = 0; m_tag = "R1";
        end else begin
            bit rise, fall, sfall;
            cq.push_front(cnv); void'(cq.pop_back());
            sq.push_front(sck); void'(sq.pop_back());
            rise  = cq[SYNC] && !cq[SYNC+1];
            fall  = !cq[SYNC] && cq[SYNC+1];
            sfall = !sq[SYNC] && sq[SYNC+1];
            m_err = (m_st == 1) && fall;
            case (m_st)
                0: if (rise) m_start("R2");
                1: begin
                    if (fall) m_tag = "R9";
                    if (m_tmr == CONV - 1) begin m_st = 2; m_tag = "R4"; end
                    else m_tmr++;
                end
                2: if (rise) m_start("R2");
                   else if (fall) begin m_st = 3; m_word = m_sample; m_idx = W - 1; m_tag = "R5"; end
                3: if (rise) m_start("R8");
                   else if (sfall) begin
                       if (m_idx == 0) begin m_st = 0; m_tag = "R7"; end
                       else begin m_idx--; m_tag = "R6"; end
                   end
                default: m_st = 0;
            endcase
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            bit exp_oe;
            exp_oe = (m_st == 3);
            checks++;
            if (oe !== exp_oe) begin
                fails++;
                $display("FAIL %s oe actual %0b expected %0b at cycle %0d", m_tag, oe, exp_oe, cycles);
            end
            checks++;
            if (err !== m_err) begin
                fails++;
                $display("FAIL R9 err actual %0b expected %0b at cycle %0d", err, m_err, cycles);
            end
            if (exp_oe) begin
                bit exp_b;
                exp_b = ((m_word >> m_idx) & 1) != 0;
                checks++;
                if (sdo !== exp_b) begin
                    fails++;
                    $display("FAIL %s sdo actual %0b expected %0b at cycle %0d", m_tag, sdo, exp_b, cycles);
                end
            end
            if (err === 1'b1) err_seen++;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic pulse_sck();
        sck = 1'b1; tick(HALF);
        sck = 1'b0; tick(HALF);
    endtask

    task automatic convert();
        cnv = 1'b1;
        tick(CONV + SYNC + 6);
    endtask

    // full read; compares the assembled word with the expected conversion index
    task automatic read_word(int exp_word);
        int rd = 0;
        cnv = 1'b0;
        tick(SYNC + 4);
        chk("R5", int'(oe), 1);
        rd = int'(sdo);
        for (int i = 1; i < W; i++) begin
            pulse_sck();
            rd = (rd << 1) | int'(sdo);
        end
        chk("R10", rd, exp_word);
        pulse_sck();
        chk("R7", int'(oe), 0);
    endtask

    initial begin
        tick(4);
        chk("R1", int'(oe), 0);
        chk("R1", int'(err), 0);
        rst_n = 1'b1;
        tick(2);
        chk("R1", int'(oe), 0);

        // conversion 0, clock falls in acquisition, then a full read
        convert();
        chk("R4", int'(oe), 0);
        pulse_sck(); pulse_sck();
        chk("R12", int'(oe), 0);
        read_word(0);
        pulse_sck(); pulse_sck();
        chk("R7", int'(oe), 0);
        chk("R12", int'(oe), 0);

        // conversion 1 with latency probe on the convert fall
        convert();
        cnv = 1'b0;
        tick(SYNC);
        chk("R11", int'(oe), 0);
        tick(1);
        chk("R11", int'(oe), 1);
        tick(3);
        read_word(1);

        // conversion 2, read aborted by a new conversion (3)
        convert();
        cnv = 1'b0;
        tick(SYNC + 4);
        for (int i = 0; i < 5; i++) pulse_sck();
        chk("R6", int'(oe), 1);
        cnv = 1'b1;
        tick(SYNC + 2);
        chk("R8", int'(oe), 0);
        tick(CONV + 4);
        read_word(3);

        // conversion 4 with an early fall and a re-rise during conversion
        err_seen = 0;
        cnv = 1'b1;
        tick(3);
        cnv = 1'b0;
        tick(SYNC + 3);
        chk("R9", err_seen, 1);
        chk("R9", int'(oe), 0);
        cnv = 1'b1;
        tick(CONV + SYNC + 6);
        chk("R3", int'(oe), 0);
        read_word(4);

        tick(10);
        summary();
    end

    initial begin
        wait (cycles > 150000);
        fails++;
        $display("FAIL watchdog actual %0d cycles expected completion", cycles);
        summary();
    end

endmodule